// File: doc/BRIEF.md
# Interrupt Pending State Controller

This block keeps the per-line interrupt state for a small processor interrupt controller. It watches a bank of peripheral request lines and tracks each one as inactive, pending, active, or active with a new request pending. Each line is configured as either level-sensitive or pulse (edge) mode. Requests come from the lines themselves and from software set-pending strobes. Software clear-pending strobes withdraw requests.

The core reports which line it is entering with an entry strobe and a line number. It reports the end of the handler with a return strobe. Only one level of activity is tracked. At every cycle the block presents the pending and active vectors and the pending line with the most urgent priority. Priorities are read from 2-bit fields packed four to a 32-bit word.

Top module: `irq_pend_ctrl`

## Requirements
- R1: While `rst_n` is low, `pend_vec` and `act_vec` are all zero and `best_valid` is 0.
- R2: A level-mode line (`pulse_mode` bit 0) whose input is 1 at a clock edge, and which is not active after that edge, reads pending from that edge on.
- R3: A pulse-mode line (`pulse_mode` bit 1) becomes pending at the first edge where its input is 1 after having been 0 at the previous edge. A one-cycle pulse is enough. A line held high does not trigger again.
- R4: A 1 in `sw_set` makes that line pending at the next edge in either mode. When `sw_set` and `sw_clr` hit the same line in the same cycle, the line ends up pending.
- R5: A 1 in `sw_clr` removes pending status at the next edge. For a level line whose input is still 1 and which is not active, the line stays pending.
- R6: When `isr_enter` is 1, then at the next edge `act_vec` equals one-hot of `isr_enter_num` and that line's pending bit clears. The only exception is a pulse line whose rising edge lands in that same cycle. At most one line is active at any time.
- R7: When `isr_return` is 1 (and `isr_enter` is 0), `act_vec` clears at the next edge. A level line then reads pending if its input is 1 at that edge, and inactive otherwise.
- R8: A pulse line that sees a rising edge while active becomes active and pending. After the return it stays pending.
- R9: The priority of line m is bits [b+7:b+6] of `prio_regs`, where b = 32*(m div 4) + 8*(m mod 4). The lower six bits of each byte are ignored. `best_num` is the pending line with the lowest field value, and ties go to the lower line number. `best_valid` is 1 exactly when some line is pending, and `best_num` is 0 otherwise.
- R10: A level line whose input stays 1 while that line is active does not become pending until the return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| irq_in | input | NUM_IRQ | Raw interrupt request lines |
| pulse_mode | input | NUM_IRQ | Per-line mode: 1 pulse, 0 level |
| sw_set | input | NUM_IRQ | Software set-pending strobes |
| sw_clr | input | NUM_IRQ | Software clear-pending strobes |
| prio_regs | input | 32*ceil(NUM_IRQ/4) | Packed priority words, one byte lane per line |
| isr_enter | input | 1 | Handler entry strobe |
| isr_enter_num | input | $clog2(NUM_IRQ) | Line being entered |
| isr_return | input | 1 | Handler return strobe |
| pend_vec | output | NUM_IRQ | Pending bit per line |
| act_vec | output | NUM_IRQ | Active bit per line |
| best_valid | output | 1 | Some line is pending |
| best_num | output | $clog2(NUM_IRQ) | Most urgent pending line |

## Verification
A wrong per-line state appears at `pend_vec` or `act_vec` on the very edge after the stimulus that caused it. This is because both vectors come straight from the state flops. Selection faults appear in `best_num` in the same cycle that the pending vector or the priority words change, since the picker is purely combinational. The cases most likely to hide a fault are the following:
- a pulse that arrives while its line is being served;
- a clear-pending write on a still-asserted level line;
- a level line that is resampled at return;
- ties and ignored low bits in the priority bytes.

The bench steers into each of these directly.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  localparam int WORD_W  = 32;
  localparam int LANE_W  = 8;
  localparam int LANES   = WORD_W / LANE_W;

  function automatic int prio_msb(input int line);
    return (line / LANES) * WORD_W + (line % LANES) * LANE_W + LANE_W - 1;
  endfunction
endpackage

// File: rtl/irq_edge_sampler.sv
module irq_edge_sampler #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  output logic [NUM_IRQ-1:0] irq_prev,
  output logic [NUM_IRQ-1:0] irq_rise
);
  logic [NUM_IRQ-1:0] prev_q;
  logic               prev_en;

  always_comb begin
    prev_en  = (prev_q != irq_in);
    irq_rise = irq_in & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_q <= '0;
    else if (prev_en) prev_q <= irq_in;
  end

  assign irq_prev = prev_q;
endmodule

// File: rtl/irq_line_state.sv
module irq_line_state (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic rise,
  input  logic pulse,
  input  logic set_req,
  input  logic clr_req,
  input  logic enter_any,
  input  logic enter_hit,
  input  logic ret,
  output logic pend,
  output logic act
);
  logic pend_q, act_q;
  logic pend_n, act_n, hw_set, clr_all, upd_en;

  always_comb begin
    if (enter_any)  act_n = enter_hit;
    else if (ret)   act_n = 1'b0;
    else            act_n = act_q;
    hw_set  = pulse ? rise : (lvl & ~act_n);
    clr_all = clr_req | enter_hit;
    pend_n  = (pend_q & ~clr_all) | hw_set | set_req;
    upd_en  = (pend_n != pend_q) | (act_n != act_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else if (upd_en) begin
      pend_q <= pend_n;
      act_q  <= act_n;
    end
  end

  assign pend = pend_q;
  assign act  = act_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_pend_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 2,
  localparam int IDW    = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
  localparam int NREG   = (NUM_IRQ + LANES - 1) / LANES
) (
  input  logic [NUM_IRQ-1:0]     pend,
  input  logic [NREG*WORD_W-1:0] prio_regs,
  output logic                   valid,
  output logic [IDW-1:0]         num
);
  logic [PRIO_W-1:0] fld [NUM_IRQ];
  logic              prio_unused;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_fld
    localparam int MSB = prio_msb(g);
    assign fld[g] = prio_regs[MSB -: PRIO_W];
  end

  assign prio_unused = ^prio_regs;

  logic [PRIO_W-1:0] best_p;

  always_comb begin
    valid  = 1'b0;
    num    = '0;
    best_p = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (pend[i] && (!valid || fld[i] < best_p)) begin
        valid  = 1'b1;
        num    = IDW'(i);
        best_p = fld[i];
      end
    end
  end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pend_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 2,
  localparam int IDW    = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
  localparam int NREG   = (NUM_IRQ + LANES - 1) / LANES
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_IRQ-1:0]     irq_in,
  input  logic [NUM_IRQ-1:0]     pulse_mode,
  input  logic [NUM_IRQ-1:0]     sw_set,
  input  logic [NUM_IRQ-1:0]     sw_clr,
  input  logic [NREG*WORD_W-1:0] prio_regs,
  input  logic                   isr_enter,
  input  logic [IDW-1:0]         isr_enter_num,
  input  logic                   isr_return,
  output logic [NUM_IRQ-1:0]     pend_vec,
  output logic [NUM_IRQ-1:0]     act_vec,
  output logic                   best_valid,
  output logic [IDW-1:0]         best_num
);
  logic [NUM_IRQ-1:0] irq_prev, irq_rise, enter_hit;

  irq_edge_sampler #(.NUM_IRQ(NUM_IRQ)) u_samp (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (irq_in),
    .irq_prev (irq_prev),
    .irq_rise (irq_rise)
  );

  always_comb begin
    enter_hit = '0;
    if (isr_enter) enter_hit[isr_enter_num] = 1'b1;
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    irq_line_state u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .lvl       (irq_in[g]),
      .rise      (irq_rise[g]),
      .pulse     (pulse_mode[g]),
      .set_req   (sw_set[g]),
      .clr_req   (sw_clr[g]),
      .enter_any (isr_enter),
      .enter_hit (enter_hit[g]),
      .ret       (isr_return),
      .pend      (pend_vec[g]),
      .act       (act_vec[g])
    );
  end

  irq_prio_pick #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_pick (
    .pend      (pend_vec),
    .prio_regs (prio_regs),
    .valid     (best_valid),
    .num       (best_num)
  );
endmodule

// File: rtl/irq_pend_ctrl_chk.sv
module irq_pend_ctrl_chk #(
  parameter int NUM_IRQ = 8,
  parameter int IDW     = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_IRQ-1:0] irq_in,
  input logic [NUM_IRQ-1:0] irq_prev,
  input logic [NUM_IRQ-1:0] pulse_mode,
  input logic [NUM_IRQ-1:0] sw_set,
  input logic [NUM_IRQ-1:0] sw_clr,
  input logic               isr_enter,
  input logic [IDW-1:0]     isr_enter_num,
  input logic               isr_return,
  input logic [NUM_IRQ-1:0] pend_vec,
  input logic [NUM_IRQ-1:0] act_vec,
  input logic               best_valid,
  input logic [IDW-1:0]     best_num
);
  always_comb begin
    if (!rst_n) assert_reset_clear_R1: assert (pend_vec == '0 && act_vec == '0);
  end

  assert_level_pends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(irq_in) & ~$past(pulse_mode)) & ~act_vec & ~pend_vec) == '0));

  assert_edge_pends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(irq_in) & ~$past(irq_prev) & $past(pulse_mode)) & ~pend_vec) == '0));

  assert_sw_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_set != '0) |=> ((pend_vec & $past(sw_set)) == $past(sw_set)));

  assert_enter_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    isr_enter |=> (act_vec == (NUM_IRQ'(1) << $past(isr_enter_num))));

  assert_single_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_vec));

  assert_return_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_return && !isr_enter) |=> (act_vec == '0));

  assert_pulse_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_return && !isr_enter) |=>
      ((($past(pend_vec) & $past(pulse_mode) & ~$past(sw_clr)) & ~pend_vec) == '0));

  assert_best_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    best_valid == (pend_vec != '0));

  assert_best_is_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    best_valid |-> pend_vec[best_num]);
endmodule

bind irq_pend_ctrl irq_pend_ctrl_chk #(.NUM_IRQ(NUM_IRQ), .IDW(IDW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .irq_in        (irq_in),
  .irq_prev      (irq_prev),
  .pulse_mode    (pulse_mode),
  .sw_set        (sw_set),
  .sw_clr        (sw_clr),
  .isr_enter     (isr_enter),
  .isr_enter_num (isr_enter_num),
  .isr_return    (isr_return),
  .pend_vec      (pend_vec),
  .act_vec       (act_vec),
  .best_valid    (best_valid),
  .best_num      (best_num)
);

// File: tb/sim_irq_pend_ctrl.sv
module sim_irq_pend_ctrl;
  localparam int N   = 8;
  localparam int IDW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_in = '0, pulse_mode = '0, sw_set = '0, sw_clr = '0;
  logic [63:0]   prio_regs = {8{8'h80}};
  logic          isr_enter = 1'b0, isr_return = 1'b0;
  logic [IDW-1:0] isr_enter_num = '0;
  logic [N-1:0]  pend_vec, act_vec;
  logic          best_valid;
  logic [IDW-1:0] best_num;

  logic [N-1:0]  m_pend = '0, m_act = '0, m_prev = '0;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_pend_ctrl #(.NUM_IRQ(N), .PRIO_W(2)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .pulse_mode(pulse_mode),
    .sw_set(sw_set), .sw_clr(sw_clr), .prio_regs(prio_regs),
    .isr_enter(isr_enter), .isr_enter_num(isr_enter_num), .isr_return(isr_return),
    .pend_vec(pend_vec), .act_vec(act_vec), .best_valid(best_valid), .best_num(best_num)
  );

  function automatic logic [1:0] fld(input int m);
    int b = (m / 4) * 32 + (m % 4) * 8;
    return prio_regs[b+7 -: 2];
  endfunction

  function automatic int model_best(input logic [N-1:0] p);
    int best = -1;
    for (int i = 0; i < N; i++)
      if (p[i] && (best < 0 || fld(i) < fld(best))) best = i;
    return best;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic model_edge();
    logic [N-1:0] act_n, hw, clrm, rise, hit;
    if (!rst_n) begin
      m_pend = '0; m_act = '0; m_prev = '0;
      return;
    end
    hit   = isr_enter ? (N'(1) << isr_enter_num) : '0;
    act_n = isr_enter ? hit : (isr_return ? '0 : m_act);
    rise  = irq_in & ~m_prev;
    hw    = (pulse_mode & rise) | (~pulse_mode & irq_in & ~act_n);
    clrm  = sw_clr | hit;
    m_pend = (m_pend & ~clrm) | hw | sw_set;
    m_act  = act_n;
    m_prev = irq_in;
  endtask

  task automatic cmp_model();
    int b = model_best(m_pend);
    chk("R2/R3/R4/R5 pending", 32'(pend_vec), 32'(m_pend));
    chk("R6/R7/R8 active", 32'(act_vec), 32'(m_act));
    chk("R9 valid", 32'(best_valid), 32'(b >= 0));
    chk("R9 num", 32'(best_num), (b >= 0) ? 32'(b) : 32'd0);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cmp_model();
    sw_set = '0; sw_clr = '0; isr_enter = 1'b0; isr_return = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    chk("R1 pend in reset", 32'(pend_vec), 0);
    chk("R1 act in reset", 32'(act_vec), 0);
    chk("R1 valid in reset", 32'(best_valid), 0);
    rst_n = 1'b1;
    pulse_mode = 8'b0010_0000;
    step();
    irq_in[2] = 1'b1; step();
    chk("R2 level pends", 32'(pend_vec), 32'h04);
    chk("R9 single pending", 32'(best_num), 2);
    irq_in[5] = 1'b1; step(); irq_in[5] = 1'b0; step(); step();
    chk("R3 pulse latched", 32'(pend_vec), 32'h24);
    prio_regs[47:40] = 8'h40; step();
    chk("R9 lane of line 5", 32'(best_num), 5);
    isr_enter = 1'b1; isr_enter_num = 3'd5; step();
    chk("R6 enter active", 32'(act_vec), 32'h20);
    chk("R6 enter clears pending", 32'(pend_vec), 32'h04);
    irq_in[5] = 1'b1; step(); irq_in[5] = 1'b0;
    chk("R8 active and pending", 32'(pend_vec & act_vec), 32'h20);
    isr_return = 1'b1; step();
    chk("R8 return keeps pending", 32'(pend_vec), 32'h24);
    chk("R7 return clears active", 32'(act_vec), 0);
    sw_clr = 8'h24; step();
    chk("R5 clear, level stays", 32'(pend_vec), 32'h04);
    isr_enter = 1'b1; isr_enter_num = 3'd2; step(); step();
    chk("R10 level not pending while active", 32'(pend_vec), 0);
    isr_return = 1'b1; step();
    chk("R7 level resampled high", 32'(pend_vec), 32'h04);
    isr_enter = 1'b1; isr_enter_num = 3'd2; step();
    irq_in[2] = 1'b0; step();
    isr_return = 1'b1; step();
    chk("R7 level resampled low", 32'(pend_vec), 0);
    chk("R7 inactive", 32'(act_vec), 0);
    sw_set = 8'h01; step();
    chk("R4 sw set", 32'(pend_vec), 32'h01);
    sw_set = 8'h01; sw_clr = 8'h01; step();
    chk("R4 set wins over clear", 32'(pend_vec), 32'h01);
    sw_clr = 8'h01; step();
    chk("R5 sw clear", 32'(pend_vec), 0);
    prio_regs = {8{8'h80}};
    sw_set = 8'h0A; step();
    chk("R9 tie lower number", 32'(best_num), 1);
    prio_regs[31:24] = 8'h00; step();
    chk("R9 lane 3 more urgent", 32'(best_num), 3);
    prio_regs[15:8] = 8'h3F; step();
    chk("R9 low bits ignored", 32'(best_num), 1);
    sw_clr = '1; step();
    chk("R9 none pending", 32'(best_valid), 0);

    for (int ph = 0; ph < 4; ph++) begin
      pulse_mode = N'($urandom);
      prio_regs  = {$urandom, $urandom};
      for (int c = 0; c < 500; c++) begin
        if ($urandom % 6 == 0) irq_in ^= N'(1) << ($urandom % N);
        if ($urandom % 12 == 0) sw_set = N'(1) << ($urandom % N);
        if ($urandom % 12 == 0) sw_clr = N'($urandom);
        if (m_act != '0 && $urandom % 5 == 0) isr_return = 1'b1;
        else if (m_act == '0 && m_pend != '0 && $urandom % 3 == 0) begin
          isr_enter = 1'b1;
          isr_enter_num = IDW'(model_best(m_pend));
        end
        step();
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule